// File: doc/BRIEF.md
# SIMD Image-Tile Processing Element

One processing element of a lockstep SIMD array. It keeps up to eight 16x16 tiles of 8-bit pixels in local memory and executes one broadcast compute instruction at a time. Each instruction combines two stored tiles pixel by pixel: the result goes to a third tile, and the second operand can be displaced by 0 to 15 pixels towards north, east, west or south. The element sweeps all 256 pixels in raster order. Each pixel takes two cycles: one to fetch both operands, one to compute and write back. The element then reports completion and accepts the next instruction.

When a displaced operand lands outside the local tile, the element sends a read request on its outgoing neighbour link. The array routes that request to the adjacent element in the displacement direction, which answers one cycle later. Every element also answers such requests from its own neighbours. At the array edge the missing neighbour answers zero. A plain write port loads tiles and a registered read port unloads them while the element is idle. The controller holds loops and branches itself and only broadcasts compute instructions.

Top module: `simd_tile_pe`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, `nb_out_req` is 0 and `rd_data` is 0.
- R2: Pixel addresses are `{tile[2:0], row[3:0], col[3:0]}`, with row 0 the north edge and col 0 the west edge. While idle, `ld_we` writes `ld_data` at `ld_addr`. `rd_data` shows the pixel at `rd_addr` one cycle later.
- R3: An instruction is taken on a clock edge where `op_valid` and `ready` are both 1. `ready` then stays 0 for exactly 512 cycles. It returns to 1 together with a one-cycle `done` pulse.
- R4: Opcode 0 adds, 1 subtracts (a-b) and 2 multiplies. All three saturate the result to 0..255.
- R5: Opcode 3 multiplies and accumulates. The accumulator is cleared when an instruction is taken and sums a*b over pixels in raster order, including the current pixel. Each pixel stores min(accumulator, 255).
- R6: Boolean opcodes: 4 AND, 5 OR, 6 XOR, 7 a AND NOT b, 8 NOT a.
- R7: Opcode 9 shifts a left and opcode 10 shifts a right, by the low 3 bits of b. Opcode 11 copies b. Zeros fill the vacated bits.
- R8: `op_dir` 0/1/2/3 = north/east/west/south, with amount k = `op_amt`. Operand b at (r,c) is source-B pixel (r-k,c), (r,c+k), (r,c-k) or (r+k,c). k=0 uses the unshifted pixel.
- R9: A displaced position outside the tile raises `nb_out_req` during that pixel's fetch cycle. `nb_out_dir` is the direction, and `nb_out_addr` holds source-B's index with row and col wrapped modulo 16. The value on `nb_out_data` one cycle later is used as b.
- R10: A request on `nb_in_req`/`nb_in_addr` is answered on `nb_in_data` with that pixel one cycle later.
- R11: While busy, `op_valid` and `ld_we` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Broadcast instruction present |
| op_code | input | 4 | Operation |
| op_dst | input | 3 | Destination tile |
| op_srca | input | 3 | Source tile A |
| op_srcb | input | 3 | Source tile B |
| op_dir | input | 2 | Displacement direction of B |
| op_amt | input | 4 | Displacement in pixels |
| ready | output | 1 | Idle, instruction can be taken |
| done | output | 1 | Sweep finished pulse |
| ld_we | input | 1 | Load write enable |
| ld_addr | input | 11 | Load address |
| ld_data | input | 8 | Load pixel |
| rd_addr | input | 11 | Unload address |
| rd_data | output | 8 | Unload pixel |
| nb_out_req | output | 1 | Read request to a neighbour |
| nb_out_dir | output | 2 | Which neighbour |
| nb_out_addr | output | 11 | Pixel requested from neighbour |
| nb_out_data | input | 8 | Neighbour answer |
| nb_in_req | input | 1 | Read request from a neighbour |
| nb_in_addr | input | 11 | Pixel requested by neighbour |
| nb_in_data | output | 8 | Answer to neighbour |

## Verification
Every opcode runs over whole tiles. The tiles are a full-range ramp, a scrambled full-range pattern and two small-valued patterns. The full-range data drives add, subtract and multiply both into and away from saturation. The small data lets multiply-accumulate stay below 255 for a few pixels before clipping, and back-to-back accumulations show that the accumulator is cleared. Displaced copies in all four directions use amounts 0, 1, 3, 5 and 15. They are checked against a modelled neighbour whose contents differ per direction, so a wrong direction, wrong wrap or wrong latency gives different pixels. The missing south neighbour shows the zero fill. A load and an instruction issued mid-sweep must leave their target tile untouched.

// File: rtl/simd_tile_pe.sv
module simd_tile_pe #(
  parameter int PW    = 8,
  parameter int TS_W  = 4,
  parameter int IMG_W = 3,
  parameter int OP_W  = 4
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [OP_W-1:0]             op_code,
  input  logic [IMG_W-1:0]            op_dst,
  input  logic [IMG_W-1:0]            op_srca,
  input  logic [IMG_W-1:0]            op_srcb,
  input  logic [1:0]                  op_dir,
  input  logic [TS_W-1:0]             op_amt,
  output logic                        ready,
  output logic                        done,
  input  logic                        ld_we,
  input  logic [IMG_W+2*TS_W-1:0]     ld_addr,
  input  logic [PW-1:0]               ld_data,
  input  logic [IMG_W+2*TS_W-1:0]     rd_addr,
  output logic [PW-1:0]               rd_data,
  output logic                        nb_out_req,
  output logic [1:0]                  nb_out_dir,
  output logic [IMG_W+2*TS_W-1:0]     nb_out_addr,
  input  logic [PW-1:0]               nb_out_data,
  input  logic                        nb_in_req,
  input  logic [IMG_W+2*TS_W-1:0]     nb_in_addr,
  output logic [PW-1:0]               nb_in_data
);
  localparam int PIX_AW = 2*TS_W;
  localparam int AW     = IMG_W + PIX_AW;
  localparam int DEPTH  = 1 << AW;
  localparam int ACC_W  = 2*PW + PIX_AW;
  localparam int SH_W   = $clog2(PW);
  localparam logic [PW-1:0] PMAX = '1;

  localparam logic [OP_W-1:0] OP_ADD = 0, OP_SUB = 1, OP_MUL = 2, OP_MAC = 3,
                              OP_AND = 4, OP_OR = 5, OP_XOR = 6, OP_ANDN = 7,
                              OP_NOT = 8, OP_SHL = 9, OP_SHR = 10, OP_PASSB = 11;

  logic [PW-1:0] mem [DEPTH];

  logic                busy, phase, oob_q, oob;
  logic [PIX_AW-1:0]   pix;
  logic [OP_W-1:0]     op_q;
  logic [IMG_W-1:0]    dst_q, sa_q, sb_q;
  logic [1:0]          dir_q;
  logic [TS_W-1:0]     amt_q, r_s, c_s;
  logic [PW-1:0]       opa, opb_loc, opb, res;
  logic [ACC_W-1:0]    acc, acc_nx;
  logic [PW:0]         sum;
  logic [2*PW-1:0]     prod;

  wire [TS_W-1:0] row = pix[PIX_AW-1:TS_W];
  wire [TS_W-1:0] col = pix[TS_W-1:0];
  wire [TS_W:0] r_n = {1'b0, row} - {1'b0, amt_q};
  wire [TS_W:0] r_p = {1'b0, row} + {1'b0, amt_q};
  wire [TS_W:0] c_n = {1'b0, col} - {1'b0, amt_q};
  wire [TS_W:0] c_p = {1'b0, col} + {1'b0, amt_q};

  always_comb begin
    r_s = row;
    c_s = col;
    oob = 1'b0;
    case (dir_q)
      2'd0:    begin r_s = r_n[TS_W-1:0]; oob = r_n[TS_W]; end
      2'd1:    begin c_s = c_p[TS_W-1:0]; oob = c_p[TS_W]; end
      2'd2:    begin c_s = c_n[TS_W-1:0]; oob = c_n[TS_W]; end
      default: begin r_s = r_p[TS_W-1:0]; oob = r_p[TS_W]; end
    endcase
  end

  assign ready       = !busy;
  assign nb_out_req  = busy && !phase && oob;
  assign nb_out_dir  = dir_q;
  assign nb_out_addr = {sb_q, r_s, c_s};

  assign opb    = oob_q ? nb_out_data : opb_loc;
  assign sum    = {1'b0, opa} + {1'b0, opb};
  assign prod   = {{PW{1'b0}}, opa} * {{PW{1'b0}}, opb};
  assign acc_nx = acc + {{(ACC_W-2*PW){1'b0}}, prod};

  always_comb begin
    case (op_code_sel(op_q))
      OP_ADD:   res = sum[PW] ? PMAX : sum[PW-1:0];
      OP_SUB:   res = (opa < opb) ? '0 : opa - opb;
      OP_MUL:   res = (|prod[2*PW-1:PW]) ? PMAX : prod[PW-1:0];
      OP_MAC:   res = (|acc_nx[ACC_W-1:PW]) ? PMAX : acc_nx[PW-1:0];
      OP_AND:   res = opa & opb;
      OP_OR:    res = opa | opb;
      OP_XOR:   res = opa ^ opb;
      OP_ANDN:  res = opa & ~opb;
      OP_NOT:   res = ~opa;
      OP_SHL:   res = opa << opb[SH_W-1:0];
      OP_SHR:   res = opa >> opb[SH_W-1:0];
      OP_PASSB: res = opb;
      default:  res = opa;
    endcase
  end

  function automatic logic [OP_W-1:0] op_code_sel(input logic [OP_W-1:0] c);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (busy && phase)
      mem[{dst_q, pix}] <= res;
    else if (!busy && ld_we)
      mem[ld_addr] <= ld_data;
    if (busy && !phase) begin
      opa     <= mem[{sa_q, pix}];
      opb_loc <= mem[nb_out_addr];
      oob_q   <= oob;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      phase      <= 1'b0;
      done       <= 1'b0;
      pix        <= '0;
      acc        <= '0;
      op_q       <= '0;
      dst_q      <= '0;
      sa_q       <= '0;
      sb_q       <= '0;
      dir_q      <= '0;
      amt_q      <= '0;
      rd_data    <= '0;
      nb_in_data <= '0;
    end else begin
      done    <= 1'b0;
      rd_data <= mem[rd_addr];
      if (nb_in_req) nb_in_data <= mem[nb_in_addr];
      if (!busy) begin
        if (op_valid) begin
          busy  <= 1'b1;
          phase <= 1'b0;
          pix   <= '0;
          acc   <= '0;
          op_q  <= op_code;
          dst_q <= op_dst;
          sa_q  <= op_srca;
          sb_q  <= op_srcb;
          dir_q <= op_dir;
          amt_q <= op_amt;
        end
      end else if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (op_q == OP_MAC) acc <= acc_nx;
        pix <= pix + 1'b1;
        if (&pix) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/simd_tile_pe_chk.sv
module simd_tile_pe_chk #(
  parameter int TS_W = 4
)(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_dir,
  input logic       ready,
  input logic       done,
  input logic       nb_out_req,
  input logic [1:0] nb_out_dir
);
  localparam int SWEEP = 2 * (1 << (2*TS_W));

  logic       busy_q;
  logic [1:0] dir_q;
  int         cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= '0;
      cnt    <= 0;
    end else if (op_valid && ready) begin
      busy_q <= 1'b1;
      dir_q  <= op_dir;
      cnt    <= 0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt <= cnt + 1;
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
  assert_sweep_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == SWEEP));
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (!ready || done));
  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nb_out_req |-> !ready);
  assert_req_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nb_out_req |-> (nb_out_dir == dir_q));
endmodule

bind simd_tile_pe simd_tile_pe_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dir(op_dir),
  .ready(ready), .done(done), .nb_out_req(nb_out_req), .nb_out_dir(nb_out_dir)
);

// File: tb/sim_simd_tile_pe.sv
module sim_simd_tile_pe;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0;
  logic [3:0] op_code = 0, op_amt = 0;
  logic [2:0] op_dst = 0, op_srca = 0, op_srcb = 0;
  logic [1:0] op_dir = 0;
  logic ready, done;
  logic ld_we = 0;
  logic [10:0] ld_addr = 0, rd_addr = 0, nb_in_addr = 0;
  logic [7:0] ld_data = 0, rd_data, nb_in_data;
  logic nb_out_req, nb_in_req = 0;
  logic [1:0] nb_out_dir;
  logic [10:0] nb_out_addr;
  logic [7:0] nb_out_data = 0;

  int total = 0, fails = 0;
  logic [3:0] nb_here = 4'b0111;
  int model [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_tile_pe u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_dst(op_dst), .op_srca(op_srca), .op_srcb(op_srcb), .op_dir(op_dir),
    .op_amt(op_amt), .ready(ready), .done(done), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .nb_out_req(nb_out_req), .nb_out_dir(nb_out_dir), .nb_out_addr(nb_out_addr),
    .nb_out_data(nb_out_data), .nb_in_req(nb_in_req), .nb_in_addr(nb_in_addr),
    .nb_in_data(nb_in_data)
  );

  function automatic int nbfun(int dir, int idx, int r, int c);
    return (dir*50 + idx*13 + r*5 + c*3 + 1) % 256;
  endfunction

  function automatic int pat(int kind, int r, int c);
    case (kind)
      0: return ((r*16 + c)*7 + 3) % 256;
      1: return (r*37 + c*11 + 5) % 256;
      2: return (r + c) % 16;
      3: return (r*3 + c) % 16;
      default: return (r ^ (c << 4)) % 256;
    endcase
  endfunction

  // Modelled neighbour array: answers one cycle after the request (R9)
  always @(posedge clk)
    if (nb_out_req)
      nb_out_data <= nb_here[nb_out_dir] ?
        8'(nbfun(int'(nb_out_dir), int'(nb_out_addr[10:8]),
                 int'(nb_out_addr[7:4]), int'(nb_out_addr[3:0]))) : 8'd0;

  function automatic int bval(int sb, int dir, int k, int r, int c);
    int rr = r, cc = c;
    case (dir)
      0: rr = r - k;
      1: cc = c + k;
      2: cc = c - k;
      default: rr = r + k;
    endcase
    if (rr >= 0 && rr < 16 && cc >= 0 && cc < 16) return model[sb*256 + rr*16 + cc];
    if (nb_here[dir]) return nbfun(dir, sb, (rr + 16) % 16, (cc + 16) % 16);
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_tile(int idx, int kind);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      ld_we = 1; ld_addr = 11'(idx*256 + p);
      ld_data = 8'(pat(kind, p/16, p%16));
      model[idx*256 + p] = pat(kind, p/16, p%16);
    end
    @(negedge clk); ld_we = 0;
  endtask

  task automatic check_tile(int idx, string tag);
    int bad = 0, fa = 0, fe = 0;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); rd_addr = 11'(idx*256 + p);
      @(negedge clk);
      if (int'(rd_data) != model[idx*256 + p]) begin
        if (bad == 0) begin fa = int'(rd_data); fe = model[idx*256 + p]; end
        bad++;
      end
    end
    total++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s tile %0d: %0d bad pixels, first actual=%0d expected=%0d",
               tag, idx, bad, fa, fe);
    end
  endtask

  task automatic run(int op, int dst, int sa, int sb, int dir, int amt,
                     string tag, bit inject);
    int res [256];
    int acc = 0, n = 0;
    for (int p = 0; p < 256; p++) begin
      int a = model[sa*256 + p];
      int b = bval(sb, dir, amt, p/16, p%16);
      int v;
      case (op)
        0: v = (a + b > 255) ? 255 : a + b;
        1: v = (a > b) ? a - b : 0;
        2: v = (a*b > 255) ? 255 : a*b;
        3: begin acc += a*b; v = (acc > 255) ? 255 : acc; end
        4: v = a & b;
        5: v = a | b;
        6: v = a ^ b;
        7: v = a & (255 - b);
        8: v = 255 - a;
        9: v = (a << (b % 8)) % 256;
        10: v = a >> (b % 8);
        default: v = b;
      endcase
      res[p] = v;
    end
    @(negedge clk);
    op_valid = 1; op_code = 4'(op); op_dst = 3'(dst); op_srca = 3'(sa);
    op_srcb = 3'(sb); op_dir = 2'(dir); op_amt = 4'(amt);
    @(negedge clk); op_valid = 0;
    while (!ready) begin
      n++;
      if (inject && n == 10) begin
        ld_we = 1; ld_addr = 11'(7*256); ld_data = 8'hAA;
        op_valid = 1; op_code = 4'd11; op_dst = 3'd7; op_srca = 3'd0; op_srcb = 3'd0;
        op_dir = 2'd0; op_amt = 4'd0;
      end
      if (inject && n == 11) begin ld_we = 0; op_valid = 0; end
      @(negedge clk);
    end
    check({tag, " R3 busy cycles"}, n, 512);
    check({tag, " R3 done with ready"}, int'(done), 1);
    for (int p = 0; p < 256; p++) model[dst*256 + p] = res[p];
    check_tile(dst, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 done", int'(done), 0);
    check("R1 nb_out_req", int'(nb_out_req), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rst_n = 1;
    load_tile(0, 0); load_tile(1, 1); load_tile(2, 2); load_tile(3, 3); load_tile(7, 4);
    check_tile(0, "R2"); check_tile(1, "R2"); check_tile(2, "R2");
    check_tile(3, "R2"); check_tile(7, "R2");

    // R10: answer to a neighbour one cycle after the request
    @(negedge clk); nb_in_req = 1; nb_in_addr = 11'(37);
    @(negedge clk); check("R10 nb_in_data", int'(nb_in_data), model[37]);
    nb_in_addr = 11'(256 + 200);
    @(negedge clk); check("R10 nb_in_data", int'(nb_in_data), model[456]);
    nb_in_req = 0;

    run(0, 4, 0, 1, 0, 0, "R4 add", 0);
    run(1, 5, 0, 1, 0, 0, "R4 sub", 0);
    run(1, 4, 1, 0, 0, 0, "R4 sub swapped", 0);
    run(2, 5, 0, 1, 0, 0, "R4 mul", 0);
    run(2, 4, 2, 3, 0, 0, "R4 mul small", 0);
    run(3, 5, 2, 3, 0, 0, "R5 mac", 0);
    run(3, 4, 2, 3, 0, 0, "R5 mac cleared", 0);
    run(4, 5, 0, 1, 0, 0, "R6 and", 0);
    run(5, 4, 0, 1, 0, 0, "R6 or", 0);
    run(6, 5, 0, 1, 0, 0, "R6 xor", 0);
    run(7, 4, 0, 1, 0, 0, "R6 andn", 0);
    run(8, 5, 0, 1, 0, 0, "R6 not", 0);
    run(9, 4, 0, 1, 0, 0, "R7 shl", 0);
    run(10, 5, 0, 1, 0, 0, "R7 shr", 0);
    run(11, 4, 0, 1, 0, 0, "R7 passb", 0);
    run(11, 5, 0, 1, 0, 1, "R8 R9 north 1", 0);
    run(11, 4, 0, 1, 1, 3, "R8 R9 east 3", 0);
    run(11, 5, 0, 1, 2, 15, "R8 R9 west 15", 0);
    run(11, 4, 0, 1, 3, 5, "R9 south 5 edge zero", 0);
    run(0, 5, 0, 1, 2, 4, "R8 R9 add west 4", 0);
    run(0, 6, 0, 1, 0, 0, "R11 inject", 1);
    check_tile(7, "R11 untouched");
    @(negedge clk); check("R11 no second sweep", int'(ready), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule